// File: doc/BRIEF.md
# Half-Duplex Collision Backoff Controller

This block decides when a half-duplex Ethernet transmitter may try a frame again after a collision. It counts the collisions seen on the current frame. It draws a pseudo-random wait of r slot times from a free-running linear feedback shift register, with r uniform over 0 to 2^k − 1, where k is the number of collisions already seen on the frame, capped at 10. It then counts that wait down one slot at a time and hands control back to the deferral logic with a one-cycle retry request. On the sixteenth collision of a frame it abandons the frame instead, reports a count of 16 and raises a completion interrupt.

Time is measured in bit-time ticks. A shared slot timer measures one slot, whose length is programmable and defaults to 512 bit times. During backoff the slot timer starts from the falling edge of transmit enable that ends the collided attempt, and it ignores carrier activity from other stations. While a transmission is in progress, the same timer measures one slot from the rising edge of carrier sense, which marks the start of the returning preamble. The block shows this as a slot-window output.

Top module: `csmacd_backoff_ctrl`

## Requirements
- R1: After reset, coll_count is 0, backoff_active, retry_req, abort_pulse, done_irq and slot_window are all 0, and the slot length is 512 ticks. The random register holds 16'hACE1.
- R2: A cycle with cfg_we high and a nonzero cfg_slot_bits sets the slot length to that many ticks from the next cycle on. A write of 0 is ignored, and the slot length stays as it was.
- R3: A collision is a cycle with col and tx_en both high while the block is idle (no backoff in progress, frame not aborted) and frame_start is low. It increments coll_count by one. col seen while tx_en is low, or during backoff, is ignored. A frame_start pulse sets coll_count to 0, clears done_irq, clears slot_window and cancels any backoff. It takes priority over a collision in the same cycle.
- R4: The random register is a 16-bit Fibonacci shift register. It advances on every clock after reset as s <= {s[14:0], s[15]^s[13]^s[12]^s[10]}. At a collision whose count before incrementing is p, the backoff value r is the low k bits of the register value held before that clock edge, with k = min(p, 10).
- R5: backoff_active is high from the cycle after a non-final collision until retry_req rises. The block waits in that state for tx_en to be low. The first cycle in which tx_en is sampled low starts the slot timer. retry_req then pulses high for exactly one cycle, in the cycle after the bit_tick that is the max(1, r·S)-th tick counted after that point, where S is the slot length. retry_req and backoff_active are never high together.
- R6: During backoff, col, crs and bit_tick activity other than tick counting neither restarts the slot timer nor changes the wait length.
- R7: On the sixteenth collision of a frame, abort_pulse is high for one cycle and coll_count reads 16 in that cycle. done_irq goes high in the same cycle and stays high until frame_start. No backoff starts, and further collisions are ignored until frame_start.
- R8: While idle with tx_en high, a rising edge of crs opens slot_window from the next cycle. The window closes after the S-th bit_tick that follows, when tx_en is sampled low, or at a collision, whichever comes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| tx_en | input | 1 | Transmitter is driving the medium |
| crs | input | 1 | Carrier sense |
| col | input | 1 | Collision indication |
| frame_start | input | 1 | Pulse before the first attempt of a new frame |
| cfg_we | input | 1 | Slot length write strobe |
| cfg_slot_bits | input | SLOT_W (16) | New slot length in bit times |
| backoff_active | output | 1 | Backoff wait in progress |
| retry_req | output | 1 | One-cycle pulse: wait finished, retry may begin |
| abort_pulse | output | 1 | One-cycle pulse: frame abandoned after too many collisions |
| done_irq | output | 1 | Completion interrupt for an aborted frame, held until frame_start |
| coll_count | output | CNT_W (5) | Collisions on the current frame, reads 16 after abort |
| slot_window | output | 1 | Slot window measured from carrier start is open |

## Verification
Every output is registered. The count, abort pulse and interrupt show their new values in the cycle after the edge that sampled the collision. The retry request appears one cycle after the clock edge that samples the deciding tick. This is max(1, r·S) ticks after the first clock edge at which transmit enable is sampled low. The bench's reference model updates on each rising edge from the inputs that the design also samples there. It compares every output on the falling edge that follows, so each result is checked in exactly the cycle it is due. Directed checks count the edges from their stimulus in the same way, and sample half a cycle after the edge that makes each result visible.

// File: rtl/csmacd_bo_pkg.sv
package csmacd_bo_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_JAM   = 2'd1,
      ST_WAIT  = 2'd2,
      ST_ABORT = 2'd3
   } bo_state_e;
endpackage

// File: rtl/cb_lfsr.sv
module cb_lfsr #(
   parameter int              W     = 16,
   parameter int              OUT_W = 12,
   parameter logic [W-1:0]    SEED  = 'hACE1
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [OUT_W-1:0] rnd
);
   logic [W-1:0] s;
   logic         fb;

   if (OUT_W > W) begin : g_bad_out
      $error("cb_lfsr: OUT_W must not exceed W");
   end

   if (W == 16) begin : g_w16
      assign fb = s[15] ^ s[13] ^ s[12] ^ s[10];
   end else if (W == 32) begin : g_w32
      assign fb = s[31] ^ s[21] ^ s[1] ^ s[0];
   end else begin : g_wbad
      assign fb = 1'b0;
      $error("cb_lfsr: only widths 16 and 32 are supported");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s <= SEED;
      else        s <= {s[W-2:0], fb};
   end

   assign rnd = s[OUT_W-1:0];
endmodule

// File: rtl/cb_slot_timer.sv
module cb_slot_timer #(
   parameter int SLOT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              run,
   input  logic [SLOT_W-1:0] slot_len,
   output logic              expire
);
   logic [SLOT_W-1:0] cnt;

   assign expire = run && !clr && (cnt >= slot_len - SLOT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (clr)    cnt <= '0;
      else if (expire) cnt <= '0;
      else if (run)    cnt <= cnt + SLOT_W'(1);
   end
endmodule

// File: rtl/cb_backoff_counter.sv
module cb_backoff_counter #(
   parameter int BO_W  = 12,
   parameter int K_CAP = 10,
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] prior_coll,
   input  logic [BO_W-1:0]  rnd,
   input  logic             dec,
   output logic             is_zero,
   output logic             is_one
);
   logic [BO_W-1:0]  value;
   logic [BO_W-1:0]  mask;
   logic [CNT_W-1:0] k;
   logic [31:0]      k_ext;

   assign k     = (prior_coll > CNT_W'(K_CAP)) ? CNT_W'(K_CAP) : prior_coll;
   assign k_ext = {{(32-CNT_W){1'b0}}, k};

   for (genvar i = 0; i < BO_W; i++) begin : g_mask
      assign mask[i] = (k_ext > 32'(i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                value <= '0;
      else if (load)             value <= rnd & mask;
      else if (dec && !is_zero)  value <= value - BO_W'(1);
   end

   assign is_zero = (value == '0);
   assign is_one  = (value == BO_W'(1));
endmodule

// File: rtl/cb_coll_counter.sv
module cb_coll_counter #(
   parameter int CNT_W    = 5,
   parameter int MAX_COLL = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] count,
   output logic             at_last
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   count <= '0;
      else if (clr) count <= '0;
      else if (inc) count <= count + CNT_W'(1);
   end

   assign at_last = (count == CNT_W'(MAX_COLL - 1));
endmodule

// File: rtl/csmacd_backoff_ctrl.sv
module csmacd_backoff_ctrl #(
   parameter int          SLOT_W       = 16,
   parameter int          SLOT_DEFAULT = 512,
   parameter int          BO_W         = 12,
   parameter int          K_CAP        = 10,
   parameter int          MAX_COLL     = 16,
   parameter int          LFSR_W       = 16,
   parameter logic [63:0] LFSR_SEED    = 64'hACE1,
   localparam int         CNT_W        = $clog2(MAX_COLL + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              tx_en,
   input  logic              crs,
   input  logic              col,
   input  logic              frame_start,
   input  logic              cfg_we,
   input  logic [SLOT_W-1:0] cfg_slot_bits,
   output logic              backoff_active,
   output logic              retry_req,
   output logic              abort_pulse,
   output logic              done_irq,
   output logic [CNT_W-1:0]  coll_count,
   output logic              slot_window
);
   import csmacd_bo_pkg::*;

   if (MAX_COLL < 2) begin : g_chk_max
      $error("csmacd_backoff_ctrl: MAX_COLL must be at least 2");
   end
   if (K_CAP > BO_W) begin : g_chk_cap
      $error("csmacd_backoff_ctrl: K_CAP exceeds backoff counter width");
   end
   if (LFSR_W < BO_W) begin : g_chk_lfsr
      $error("csmacd_backoff_ctrl: LFSR narrower than backoff counter");
   end
   if (SLOT_DEFAULT < 1 || SLOT_DEFAULT >= (2 ** SLOT_W)) begin : g_chk_slot
      $error("csmacd_backoff_ctrl: SLOT_DEFAULT out of range");
   end

   bo_state_e         st;
   logic [SLOT_W-1:0] slot_len_q;
   logic              crs_q;
   logic              tx_win;
   logic [BO_W-1:0]   rnd;
   logic              slot_exp;
   logic              bo_zero, bo_one;
   logic              at_last;
   logic              coll_ev, win_start, jam_end, slot_clr, slot_run;
   logic              retry_now, bo_dec;

   assign coll_ev   = (st == ST_IDLE) && tx_en && col && !frame_start;
   assign win_start = (st == ST_IDLE) && tx_en && crs && !crs_q && !frame_start && !coll_ev;
   assign jam_end   = (st == ST_JAM) && !tx_en && !frame_start;
   assign slot_clr  = win_start || jam_end;
   assign slot_run  = bit_tick && ((st == ST_WAIT) || tx_win);
   assign retry_now = (st == ST_WAIT) && bit_tick && !frame_start &&
                      (bo_zero || (slot_exp && bo_one));
   assign bo_dec    = (st == ST_WAIT) && slot_exp && !frame_start;

   cb_lfsr #(
      .W     (LFSR_W),
      .OUT_W (BO_W),
      .SEED  (LFSR_SEED[LFSR_W-1:0])
   ) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .rnd   (rnd)
   );

   cb_slot_timer #(.SLOT_W(SLOT_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (slot_clr),
      .run      (slot_run),
      .slot_len (slot_len_q),
      .expire   (slot_exp)
   );

   cb_backoff_counter #(
      .BO_W  (BO_W),
      .K_CAP (K_CAP),
      .CNT_W (CNT_W)
   ) u_bo (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (coll_ev && !at_last),
      .prior_coll (coll_count),
      .rnd        (rnd),
      .dec        (bo_dec),
      .is_zero    (bo_zero),
      .is_one     (bo_one)
   );

   cb_coll_counter #(
      .CNT_W    (CNT_W),
      .MAX_COLL (MAX_COLL)
   ) u_cc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (frame_start),
      .inc     (coll_ev),
      .count   (coll_count),
      .at_last (at_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              slot_len_q <= SLOT_W'(SLOT_DEFAULT);
      else if (cfg_we && cfg_slot_bits != '0)  slot_len_q <= cfg_slot_bits;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         crs_q       <= 1'b0;
         tx_win      <= 1'b0;
         retry_req   <= 1'b0;
         abort_pulse <= 1'b0;
         done_irq    <= 1'b0;
      end else begin
         crs_q       <= crs;
         retry_req   <= retry_now;
         abort_pulse <= coll_ev && at_last;

         if (frame_start)                done_irq <= 1'b0;
         else if (coll_ev && at_last)    done_irq <= 1'b1;

         if (frame_start || coll_ev || !tx_en || st != ST_IDLE) tx_win <= 1'b0;
         else if (win_start)                                    tx_win <= 1'b1;
         else if (tx_win && slot_exp)                           tx_win <= 1'b0;

         if (frame_start) begin
            st <= ST_IDLE;
         end else begin
            unique case (st)
               ST_IDLE:  if (coll_ev) st <= at_last ? ST_ABORT : ST_JAM;
               ST_JAM:   if (jam_end) st <= ST_WAIT;
               ST_WAIT:  if (retry_now) st <= ST_IDLE;
               ST_ABORT: st <= ST_ABORT;
               default:  st <= ST_IDLE;
            endcase
         end
      end
   end

   assign backoff_active = (st == ST_JAM) || (st == ST_WAIT);
   assign slot_window    = tx_win;
endmodule

// File: rtl/cb_backoff_checker.sv
module cb_backoff_checker #(
   parameter int CNT_W    = 5,
   parameter int MAX_COLL = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             frame_start,
   input logic             backoff_active,
   input logic             retry_req,
   input logic             abort_pulse,
   input logic             done_irq,
   input logic [CNT_W-1:0] coll_count,
   input logic             slot_window
);
   assert_retry_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      retry_req |=> !retry_req);

   assert_retry_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      retry_req |-> !backoff_active);

   assert_abort_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
      abort_pulse |-> (coll_count == CNT_W'(MAX_COLL)) && done_irq);

   assert_abort_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      abort_pulse |=> !abort_pulse);

   assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_irq && !frame_start) |=> done_irq);

   assert_start_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (coll_count == '0) && !done_irq && !backoff_active);

   assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      coll_count <= CNT_W'(MAX_COLL));

   assert_window_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      slot_window |-> !backoff_active);
endmodule

bind csmacd_backoff_ctrl cb_backoff_checker #(
   .CNT_W    (CNT_W),
   .MAX_COLL (MAX_COLL)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .frame_start    (frame_start),
   .backoff_active (backoff_active),
   .retry_req      (retry_req),
   .abort_pulse    (abort_pulse),
   .done_irq       (done_irq),
   .coll_count     (coll_count),
   .slot_window    (slot_window)
);

// File: tb/sim_csmacd_backoff_ctrl.sv
`timescale 1ns/1ps
module sim_csmacd_backoff_ctrl;
   logic        clk = 1'b0, rst_n = 1'b0;
   logic        bit_tick = 1'b0, tx_en = 1'b0, crs = 1'b0, col = 1'b0;
   logic        frame_start = 1'b0, cfg_we = 1'b0;
   logic [15:0] cfg_slot_bits = '0;
   logic        backoff_active, retry_req, abort_pulse, done_irq, slot_window;
   logic [4:0]  coll_count;

   csmacd_backoff_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en), .crs(crs),
      .col(col), .frame_start(frame_start), .cfg_we(cfg_we),
      .cfg_slot_bits(cfg_slot_bits), .backoff_active(backoff_active),
      .retry_req(retry_req), .abort_pulse(abort_pulse), .done_irq(done_irq),
      .coll_count(coll_count), .slot_window(slot_window)
   );

   always #4 clk = ~clk;

   int n_chk = 0, n_fail = 0, cyc_cnt = 0;
   bit finished = 1'b0;
   int tick_div = 1, tph = 0;

   always @(negedge clk) begin
      tph      <= tph + 1;
      bit_tick <= ((tph + 1) % tick_div) == 0;
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run;
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   // Behavioural reference: wait lengths held as tick targets, not slot countdowns
   int          m_st = 0, m_cnt = 0, m_target = 0, m_ticks = 0, m_wticks = 0;
   int          m_slot = 512;
   bit          m_win = 0, m_crs_q = 0, m_retry = 0, m_abort = 0, m_irq = 0;
   logic [15:0] m_lfsr = 16'hACE1;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_win = 0; m_crs_q = 0; m_retry = 0; m_abort = 0;
         m_irq = 0; m_slot = 512; m_lfsr = 16'hACE1; m_ticks = 0; m_wticks = 0;
      end else begin
         bit nr, na, ev, ws;
         int k, r;
         nr = 0; na = 0;
         ev = (m_st == 0) && tx_en && col && !frame_start;
         ws = (m_st == 0) && tx_en && crs && !m_crs_q && !frame_start && !ev;
         if (frame_start) begin
            m_st = 0; m_cnt = 0; m_irq = 0; m_win = 0;
         end else if (m_st == 0) begin
            if (ev) begin
               k = (m_cnt > 10) ? 10 : m_cnt;
               m_cnt++;
               m_win = 0;
               if (m_cnt == 16) begin
                  na = 1; m_irq = 1; m_st = 3;
               end else begin
                  r = int'(m_lfsr) % (1 << k);
                  m_target = (r == 0) ? 1 : r * m_slot;
                  m_st = 1;
               end
            end else if (!tx_en) m_win = 0;
            else if (ws) begin
               m_win = 1; m_wticks = 0;
            end else if (m_win && bit_tick) begin
               m_wticks++;
               if (m_wticks >= m_slot) m_win = 0;
            end
         end else if (m_st == 1) begin
            if (!tx_en) begin m_st = 2; m_ticks = 0; end
         end else if (m_st == 2) begin
            if (bit_tick) begin
               m_ticks++;
               if (m_ticks == m_target) begin nr = 1; m_st = 0; end
            end
         end
         if (cfg_we && cfg_slot_bits != 0) m_slot = int'(cfg_slot_bits);
         m_crs_q = crs;
         m_lfsr  = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
         m_retry = nr;
         m_abort = na;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check(retry_req == m_retry, "R4/R5/R6 retry_req", retry_req, m_retry);
         check(backoff_active == (m_st == 1 || m_st == 2), "R5 backoff_active",
               backoff_active, (m_st == 1 || m_st == 2));
         check(coll_count == m_cnt, "R3 coll_count", coll_count, m_cnt);
         check(abort_pulse == m_abort, "R7 abort_pulse", abort_pulse, m_abort);
         check(done_irq == m_irq, "R7 done_irq", done_irq, m_irq);
         check(slot_window == m_win, "R8/R2 slot_window", slot_window, m_win);
      end
   end

   always @(posedge clk) begin
      cyc_cnt++;
      if (cyc_cnt > 190000 && !finished) begin
         n_fail++;
         $display("FAIL watchdog expired (all requirements) actual=%0d expected=%0d", cyc_cnt, 0);
         finish_run();
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_start;
      frame_start = 1'b1; cyc(1); frame_start = 1'b0;
   endtask

   task automatic set_slot(input int v);
      cfg_we = 1'b1; cfg_slot_bits = 16'(v); cyc(1); cfg_we = 1'b0;
   endtask

   task automatic attempt(input bit collide, input int hold, input bit noise);
      tx_en = 1'b1; cyc(2); crs = 1'b1; cyc(3);
      if (collide) begin
         col = 1'b1; cyc(1); col = 1'b0; cyc(3);
         tx_en = 1'b0; crs = 1'b0;
         for (int i = 0; i < 150000; i++) begin
            cyc(1);
            crs = noise && (i % 7 == 3);
            col = noise && (i % 11 == 5);
            if (!backoff_active) break;
         end
         crs = 1'b0; col = 1'b0; cyc(1);
      end else begin
         cyc(hold); tx_en = 1'b0; crs = 1'b0; cyc(2);
      end
   endtask

   initial begin
      cyc(3);
      // R1: reset state
      check(coll_count == 0, "R1 reset coll_count", coll_count, 0);
      check(backoff_active == 0, "R1 reset backoff_active", backoff_active, 0);
      check(retry_req == 0, "R1 reset retry_req", retry_req, 0);
      check(done_irq == 0, "R1 reset done_irq", done_irq, 0);
      check(slot_window == 0, "R1 reset slot_window", slot_window, 0);
      rst_n = 1'b1;
      cyc(2);

      // R5: first collision of a frame (k = 0) retries on the first tick
      pulse_start();
      tx_en = 1'b1; crs = 1'b1; cyc(2);
      col = 1'b1; cyc(1); col = 1'b0;
      check(backoff_active == 1, "R5 active after collision", backoff_active, 1);
      check(coll_count == 1, "R3 count after collision", coll_count, 1);
      cyc(2); tx_en = 1'b0; crs = 1'b0; cyc(1);
      check(retry_req == 0, "R5 no retry before tick", retry_req, 0);
      cyc(1);
      check(retry_req == 1, "R5 r=0 retry on first tick", retry_req, 1);
      check(backoff_active == 0, "R5 inactive with retry", backoff_active, 0);
      cyc(2);

      // R3: col without tx_en is ignored
      col = 1'b1; cyc(3); col = 1'b0; cyc(1);
      check(coll_count == 1, "R3 col without tx_en ignored", coll_count, 1);

      // R1/R8: default slot, second collision with k = 1, window from carrier
      attempt(1'b1, 0, 1'b1);
      check(coll_count == 2, "R3 second collision counted", coll_count, 2);
      attempt(1'b0, 600, 1'b0);
      check(coll_count == 2, "R3 success keeps count", coll_count, 2);

      // R3: frame_start beats a same-cycle collision
      tx_en = 1'b1; crs = 1'b1; cyc(2);
      col = 1'b1; frame_start = 1'b1; cyc(1); col = 1'b0; frame_start = 1'b0;
      check(coll_count == 0, "R3 frame_start priority", coll_count, 0);
      check(backoff_active == 0, "R3 no backoff on start", backoff_active, 0);
      tx_en = 1'b0; crs = 1'b0; cyc(2);

      // R2: zero write ignored, then slot of 3 ticks with slower ticks
      set_slot(0);
      attempt(1'b0, 520, 1'b0);
      set_slot(3);
      tick_div = 2;
      cyc(2);
      attempt(1'b0, 40, 1'b0);

      // R7: sixteen collisions abort the frame
      pulse_start();
      for (int n = 0; n < 16; n++) attempt(1'b1, 0, n[0]);
      check(coll_count == 16, "R7 count reads 16", coll_count, 16);
      check(done_irq == 1, "R7 irq raised", done_irq, 1);
      check(backoff_active == 0, "R7 no backoff after abort", backoff_active, 0);
      attempt(1'b1, 0, 1'b0);
      check(coll_count == 16, "R7 collisions ignored after abort", coll_count, 16);
      check(done_irq == 1, "R7 irq held", done_irq, 1);
      pulse_start();
      cyc(1);
      check(done_irq == 0, "R3 irq cleared by start", done_irq, 0);
      check(coll_count == 0, "R3 count cleared by start", coll_count, 0);

      // R4: exponent cap beyond ten collisions, one-tick slots
      set_slot(1);
      tick_div = 1;
      for (int n = 0; n < 13; n++) attempt(1'b1, 0, 1'b1);
      check(coll_count == 13, "R4 thirteen collisions counted", coll_count, 13);
      attempt(1'b0, 10, 1'b0);
      pulse_start();
      cyc(4);
      finish_run();
   end
endmodule